// File: doc/BRIEF.md
# Banked GPIO Controller with Bit Set/Clear Aliases

This block runs one bank of 32 general-purpose pins from a simple APB-style register port. For each pin it stores an output level, a direction, a pull-off flag and a two-bit function selector. It drives the pad controls from that state: output value, output enable, pull enable, pull polarity, and a function code that steers the pin mux. Pins are numbered across a chip as bank = index/32 and bit = index mod 32. This block is one bank.

Software can change single bits of the level and direction registers with one write and no read-modify-write. Each of those registers has a set alias and a clear alias. A bit written as 1 is acted on and a bit written as 0 is left alone. The level register has a second job on input pins. When the pull is on, the stored level bit chooses pull-up (1) or pull-down (0).

Pad inputs go through a two-flop synchronizer. The synchronized values feed the level readback and per-pin edge detection. A rising edge or a falling edge, each with its own mask, sets a sticky status bit. Software clears status bits by writing ones. The single interrupt line is the OR of all status bits.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is an input (`pad_oe` = 0) with no pull (`pull_en` = 0, pull-off register at 0x0C reads all ones). Every function code is 00, the level and direction registers read 0, and `irq` is 0.
- R2: A write to 0x04 sets each level bit written as 1, and a write to 0x08 clears each level bit written as 1. Bits written as 0 keep their value. `pad_out` always equals the stored level bits.
- R3: A write to 0x14 sets and a write to 0x18 clears direction bits in the same write-one manner. `pad_oe[i]` equals direction bit i, where 1 means output.
- R4: Writes to 0x00 (level), 0x0C (pull-off), 0x10 (direction), 0x20 (function low bit) and 0x24 (function high bit) replace the whole register. Offsets 0x0C, 0x10, 0x20 and 0x24 read back the stored value. No state changes in a cycle without a write.
- R5: `pull_en[i]` is 1 only when pull-off bit i is 0 and pin i is an input. `pull_up[i]` is level bit i while `pull_en[i]` is 1, and 0 otherwise.
- R6: On an output pin, writing the level bit to change the pull choice changes the driven `pad_out` level.
- R7: `fsel[2i+1:2i]` = {bit i of 0x24, bit i of 0x20}. Code 00 is plain GPIO and codes 01, 10 and 11 pick alternate functions A, B and C.
- R8: A read of 0x00 returns the stored level bit for output pins and the synchronized pad level for input pins. A pad change shows up after two clock edges.
- R9: The rising-edge mask sits at 0x40 and the falling-edge mask at 0x44, both readable. A status bit (read at 0x48) is set on an edge of the synchronized input only when that edge's mask bit is 1. It is set on the third clock edge after the pad changes. Masked edges leave status unchanged.
- R10: Writing 1 to a bit of 0x4C clears that status bit, and 0 bits leave it set. `irq` is 1 exactly when any status bit is 1.
- R11: Reads of unused offsets (including 0x1C, 0x30 and 0x4C) return 0. Writes to unused offsets change no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | NPINS | Write data |
| prdata | output | NPINS | Read data (combinational while selected for read) |
| pad_in | input | NPINS | Raw pad levels |
| pad_out | output | NPINS | Output level per pin |
| pad_oe | output | NPINS | Output enable per pin |
| pull_en | output | NPINS | Pull enable per pin |
| pull_up | output | NPINS | Pull polarity, 1 = up |
| fsel | output | 2*NPINS | Function code, two bits per pin |
| irq | output | 1 | OR of all edge status bits |

## Verification
On every cycle, the assertions check the set/clear alias arithmetic on level and direction, that registers hold when no write happens, that no status bit appears without a mask bit enabling it, and that a clear write leaves no cleared bit set unless a new edge arrived in the same cycle. Other behaviour shows only in the bench scenarios. These include the exact three-edge latency from pad to status, the mixed output/input readback of the level register, the pull-polarity side effect on output pins, the function-code packing and the zero reads of unused offsets. The bench drives random register traffic against a model and adds directed edge and clear sequences.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_LEVEL,
        SEL_LSET,
        SEL_LCLR,
        SEL_NOPULL,
        SEL_DIR,
        SEL_DSET,
        SEL_DCLR,
        SEL_FLO,
        SEL_FHI,
        SEL_RMASK,
        SEL_FMASK,
        SEL_STAT,
        SEL_ICLR
    } reg_sel_e;

    // Byte offsets within the low seven address bits
    localparam logic [6:0] OFS_LEVEL  = 7'h00;
    localparam logic [6:0] OFS_LSET   = 7'h04;
    localparam logic [6:0] OFS_LCLR   = 7'h08;
    localparam logic [6:0] OFS_NOPULL = 7'h0C;
    localparam logic [6:0] OFS_DIR    = 7'h10;
    localparam logic [6:0] OFS_DSET   = 7'h14;
    localparam logic [6:0] OFS_DCLR   = 7'h18;
    localparam logic [6:0] OFS_FLO    = 7'h20;
    localparam logic [6:0] OFS_FHI    = 7'h24;
    localparam logic [6:0] OFS_RMASK  = 7'h40;
    localparam logic [6:0] OFS_FMASK  = 7'h44;
    localparam logic [6:0] OFS_STAT   = 7'h48;
    localparam logic [6:0] OFS_ICLR   = 7'h4C;

    function automatic reg_sel_e decode_ofs(input logic [6:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_LEVEL:  s = SEL_LEVEL;
            OFS_LSET:   s = SEL_LSET;
            OFS_LCLR:   s = SEL_LCLR;
            OFS_NOPULL: s = SEL_NOPULL;
            OFS_DIR:    s = SEL_DIR;
            OFS_DSET:   s = SEL_DSET;
            OFS_DCLR:   s = SEL_DCLR;
            OFS_FLO:    s = SEL_FLO;
            OFS_FHI:    s = SEL_FHI;
            OFS_RMASK:  s = SEL_RMASK;
            OFS_FMASK:  s = SEL_FMASK;
            OFS_STAT:   s = SEL_STAT;
            OFS_ICLR:   s = SEL_ICLR;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    assign chain_d[0] = din;

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            assign chain_d[s] = chain_q[s-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] level_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] nopull_q,
    output logic [W-1:0] flo_q,
    output logic [W-1:0] fhi_q
);
    typedef struct packed {
        logic [W-1:0] level;
        logic [W-1:0] dir;
        logic [W-1:0] nopull;
        logic [W-1:0] flo;
        logic [W-1:0] fhi;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (sel)
                SEL_LEVEL:  cfg_d.level  = wdata;
                SEL_LSET:   cfg_d.level  = cfg_q.level | wdata;
                SEL_LCLR:   cfg_d.level  = cfg_q.level & ~wdata;
                SEL_NOPULL: cfg_d.nopull = wdata;
                SEL_DIR:    cfg_d.dir    = wdata;
                SEL_DSET:   cfg_d.dir    = cfg_q.dir | wdata;
                SEL_DCLR:   cfg_d.dir    = cfg_q.dir & ~wdata;
                SEL_FLO:    cfg_d.flo    = wdata;
                SEL_FHI:    cfg_d.fhi    = wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.level  <= '0;
            cfg_q.dir    <= '0;
            cfg_q.nopull <= '1;
            cfg_q.flo    <= '0;
            cfg_q.fhi    <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign level_q  = cfg_q.level;
    assign dir_q    = cfg_q.dir;
    assign nopull_q = cfg_q.nopull;
    assign flo_q    = cfg_q.flo;
    assign fhi_q    = cfg_q.fhi;

    AST_LEVEL_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_LSET) |=> (level_q == ($past(level_q) | $past(wdata)))); // R2
    AST_LEVEL_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_LCLR) |=> (level_q == ($past(level_q) & ~$past(wdata)))); // R2
    AST_DIR_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DSET) |=> (dir_q == ($past(dir_q) | $past(wdata)))); // R3
    AST_DIR_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DCLR) |=> (dir_q == ($past(dir_q) & ~$past(wdata)))); // R3
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(level_q) && $stable(dir_q) && $stable(nopull_q)
                    && $stable(flo_q) && $stable(fhi_q))); // R4
endmodule

// File: rtl/gpio_irq.sv
`timescale 1ns/1ps
module gpio_irq
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rmask_q,
    output logic [W-1:0] fmask_q,
    output logic [W-1:0] status_q,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] rmask;
        logic [W-1:0] fmask;
        logic [W-1:0] status;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic [W-1:0] rise_ev, fall_ev, clr_bits;

    always_comb begin
        rise_ev  = pin & ~st_q.prev & st_q.rmask;
        fall_ev  = ~pin & st_q.prev & st_q.fmask;
        clr_bits = (wr_en && sel == SEL_ICLR) ? wdata : '0;
        st_d        = st_q;
        st_d.prev   = pin;
        if (wr_en && sel == SEL_RMASK) st_d.rmask = wdata;
        if (wr_en && sel == SEL_FMASK) st_d.fmask = wdata;
        st_d.status = (st_q.status & ~clr_bits) | rise_ev | fall_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rmask_q  = st_q.rmask;
    assign fmask_q  = st_q.fmask;
    assign status_q = st_q.status;
    assign irq      = |st_q.status;

    AST_STATUS_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~($past(rmask_q) | $past(fmask_q))) == '0)); // R9
    AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_ICLR) |=> ((status_q & $past(wdata) & ~$past(rise_ev | fall_ev)) == '0)); // R10
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [NPINS-1:0]     pwdata,
    output logic [NPINS-1:0]     prdata,
    input  logic [NPINS-1:0]     pad_in,
    output logic [NPINS-1:0]     pad_out,
    output logic [NPINS-1:0]     pad_oe,
    output logic [NPINS-1:0]     pull_en,
    output logic [NPINS-1:0]     pull_up,
    output logic [2*NPINS-1:0]   fsel,
    output logic                 irq
);
    localparam int FS_W = 2;

    reg_sel_e         sel;
    logic             wr_en;
    logic [NPINS-1:0] pin_sync, level_q, dir_q, nopull_q, flo_q, fhi_q;
    logic [NPINS-1:0] rmask_q, fmask_q, status_q, level_rd;

    assign sel   = (paddr[ADDR_W-1:7] == '0) ? decode_ofs(paddr[6:0]) : SEL_NONE;
    assign wr_en = psel & penable & pwrite;

    gpio_sync #(.W(NPINS), .STAGES(SYNC_N)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync)
    );

    gpio_regs #(.W(NPINS)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(pwdata),
        .level_q(level_q), .dir_q(dir_q), .nopull_q(nopull_q),
        .flo_q(flo_q), .fhi_q(fhi_q)
    );

    gpio_irq #(.W(NPINS)) irq_i (
        .clk(clk), .rst_n(rst_n), .pin(pin_sync), .wr_en(wr_en), .sel(sel),
        .wdata(pwdata), .rmask_q(rmask_q), .fmask_q(fmask_q),
        .status_q(status_q), .irq(irq)
    );

    assign pad_out  = level_q;
    assign pad_oe   = dir_q;
    assign pull_en  = ~nopull_q & ~dir_q;
    assign pull_up  = level_q & pull_en;
    assign level_rd = (dir_q & level_q) | (~dir_q & pin_sync);

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_fsel
            assign fsel[FS_W*i +: FS_W] = {fhi_q[i], flo_q[i]};
        end
    endgenerate

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (sel)
                SEL_LEVEL:  prdata = level_rd;
                SEL_NOPULL: prdata = nopull_q;
                SEL_DIR:    prdata = dir_q;
                SEL_FLO:    prdata = flo_q;
                SEL_FHI:    prdata = fhi_q;
                SEL_RMASK:  prdata = rmask_q;
                SEL_FMASK:  prdata = fmask_q;
                SEL_STAT:   prdata = status_q;
                default:    prdata = '0;
            endcase
        end
    end
endmodule

// File: tb/gpio_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0, prdata, pad_in = '0;
    logic [31:0] pad_out, pad_oe, pull_en, pull_up;
    logic [63:0] fsel;
    logic        irq;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [31:0] m_lvl = '0, m_dir = '0, m_nop = '1, m_flo = '0, m_fhi = '0;

    always #4 clk = ~clk;

    gpio_bank dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en), .pull_up(pull_up),
        .fsel(fsel), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1; d = prdata;
        psel = 0; penable = 0;
    endtask

    function automatic logic [63:0] exp_fsel(input logic [31:0] lo, input logic [31:0] hi);
        logic [63:0] r;
        for (int i = 0; i < 32; i++) r[2*i +: 2] = {hi[i], lo[i]};
        return r;
    endfunction

    function automatic logic [31:0] exp_level(input logic [31:0] pads);
        return (m_dir & m_lvl) | (~m_dir & pads);
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h00: m_lvl = d;
            8'h04: m_lvl = m_lvl | d;
            8'h08: m_lvl = m_lvl & ~d;
            8'h0C: m_nop = d;
            8'h10: m_dir = d;
            8'h14: m_dir = m_dir | d;
            8'h18: m_dir = m_dir & ~d;
            8'h20: m_flo = d;
            8'h24: m_fhi = d;
            default: ;
        endcase
    endtask

    task automatic check_outputs(input string tag);
        chk({tag, " R2 pad_out"}, {32'd0, pad_out}, {32'd0, m_lvl});
        chk({tag, " R3 pad_oe"}, {32'd0, pad_oe}, {32'd0, m_dir});
        chk({tag, " R5 pull_en"}, {32'd0, pull_en}, {32'd0, ~m_nop & ~m_dir});
        chk({tag, " R5 pull_up"}, {32'd0, pull_up}, {32'd0, m_lvl & ~m_nop & ~m_dir});
        chk({tag, " R7 fsel"}, fsel, exp_fsel(m_flo, m_fhi));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [7:0] addrs [11] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                                   8'h18, 8'h1C, 8'h20, 8'h24, 8'h30};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe", {32'd0, pad_oe}, 64'd0);
        chk("R1 pull_en", {32'd0, pull_en}, 64'd0);
        chk("R1 fsel", fsel, 64'd0);
        chk("R1 irq", {63'd0, irq}, 64'd0);
        bus_read(8'h0C, rd); chk("R1 nopull read", {32'd0, rd}, {32'd0, 32'hFFFF_FFFF});
        bus_read(8'h10, rd); chk("R1 dir read", {32'd0, rd}, 64'd0);
        bus_read(8'h00, rd); chk("R1 level read", {32'd0, rd}, 64'd0);

        // R2 directed set/clear leave zero bits alone
        bus_write(8'h00, 32'hF0F0_0000); model_write(8'h00, 32'hF0F0_0000);
        bus_write(8'h04, 32'h0000_000F); model_write(8'h04, 32'h0000_000F);
        chk("R2 set alias", {32'd0, pad_out}, {32'd0, 32'hF0F0_000F});
        bus_write(8'h08, 32'h8000_0001); model_write(8'h08, 32'h8000_0001);
        chk("R2 clear alias", {32'd0, pad_out}, {32'd0, 32'h70F0_000E});

        // R5/R6 pull selection on input, then driven-level side effect on output
        bus_write(8'h0C, 32'hFFFF_FFFC); model_write(8'h0C, 32'hFFFF_FFFC);
        chk("R5 pull_en inputs", {32'd0, pull_en}, 64'h3);
        chk("R5 pull_up sel", {32'd0, pull_up}, 64'h2);
        bus_write(8'h14, 32'h0000_0002); model_write(8'h14, 32'h0000_0002);
        chk("R5 pull off for output", {32'd0, pull_en}, 64'h1);
        bus_write(8'h08, 32'h0000_0002); model_write(8'h08, 32'h0000_0002);
        chk("R6 output level follows pull choice", {63'd0, pad_out[1]}, 64'd0);

        // R7 all four function codes
        bus_write(8'h20, 32'h0000_000A); model_write(8'h20, 32'h0000_000A);
        bus_write(8'h24, 32'h0000_000C); model_write(8'h24, 32'h0000_000C);
        chk("R7 codes 00/01/10/11", {56'd0, fsel[7:0]}, {56'd0, 8'b11_10_01_00});

        // R8 pad sync latency on an input pin
        bus_write(8'h10, 32'h0000_00F0); model_write(8'h10, 32'h0000_00F0);
        @(negedge clk); pad_in = 32'h0000_0F0F;
        @(negedge clk);
        @(negedge clk);
        bus_read(8'h00, rd); chk("R8 mixed level read", {32'd0, rd}, {32'd0, exp_level(32'h0000_0F0F)});

        // Random register traffic, R2 R3 R4 R11
        for (int it = 0; it < 300; it++) begin
            logic [7:0] a;
            logic [31:0] d;
            a = addrs[$urandom % 11];
            d = $urandom;
            bus_write(a, d); model_write(a, d);
            check_outputs("rand");
            if ((it % 10) == 0) begin
                pad_in = $urandom;
                repeat (3) @(negedge clk);
                bus_read(8'h00, rd); chk("R8 rand level", {32'd0, rd}, {32'd0, exp_level(pad_in)});
                bus_read(8'h10, rd); chk("R4 dir read", {32'd0, rd}, {32'd0, m_dir});
                bus_read(8'h0C, rd); chk("R4 nopull read", {32'd0, rd}, {32'd0, m_nop});
                bus_read(8'h20, rd); chk("R4 flo read", {32'd0, rd}, {32'd0, m_flo});
                bus_read(8'h24, rd); chk("R4 fhi read", {32'd0, rd}, {32'd0, m_fhi});
            end
        end

        // R11 unused offsets read zero
        bus_read(8'h1C, rd); chk("R11 read 0x1C", {32'd0, rd}, 64'd0);
        bus_read(8'h30, rd); chk("R11 read 0x30", {32'd0, rd}, 64'd0);
        bus_read(8'h4C, rd); chk("R11 read 0x4C", {32'd0, rd}, 64'd0);
        bus_write(8'h1C, 32'hFFFF_FFFF);
        check_outputs("R11 write 0x1C");

        // R9/R10 edge interrupts
        bus_write(8'h10, 32'h0); model_write(8'h10, 32'h0);
        pad_in = 32'h0;
        repeat (4) @(negedge clk);
        bus_write(8'h4C, 32'hFFFF_FFFF);
        bus_write(8'h40, 32'h0000_0008);
        bus_write(8'h44, 32'h0000_0020);
        bus_read(8'h40, rd); chk("R9 rise mask read", {32'd0, rd}, 64'h8);
        bus_read(8'h44, rd); chk("R9 fall mask read", {32'd0, rd}, 64'h20);
        @(negedge clk); pad_in = 32'h0000_00A8;
        @(negedge clk); chk("R9 irq after 1 edge", {63'd0, irq}, 64'd0);
        @(negedge clk); chk("R9 irq after 2 edges", {63'd0, irq}, 64'd0);
        @(negedge clk); chk("R9 irq after 3 edges", {63'd0, irq}, 64'd1);
        bus_read(8'h48, rd); chk("R9 only unmasked rise", {32'd0, rd}, 64'h8);
        pad_in = 32'h0;
        repeat (4) @(negedge clk);
        bus_read(8'h48, rd); chk("R9 masked falls ignored except bit5", {32'd0, rd}, 64'h28);
        bus_write(8'h4C, 32'h0000_0008);
        bus_read(8'h48, rd); chk("R10 partial clear", {32'd0, rd}, 64'h20);
        chk("R10 irq still set", {63'd0, irq}, 64'd1);
        bus_write(8'h4C, 32'h0000_0020);
        chk("R10 irq low after clear", {63'd0, irq}, 64'd0);
        bus_read(8'h48, rd); chk("R10 status empty", {32'd0, rd}, 64'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule